// File: doc/BRIEF.md
# Serial Port Interrupt Factor Controller

This block collects the interrupt sources of a serial port and turns them into one request line and a vector address for the CPU. Three factors are tracked: transmit done, receive done and receive error. The transmit engine sends a one-cycle pulse when a frame has been shifted out. The receive engine sends a one-cycle pulse when a received frame moves into the receive buffer. That pulse carries parity, framing and overrun qualifiers that are valid in the same cycle.

Each factor has a sticky flag and an enable bit. A flag records its event even while the factor is disabled; the enable only gates the request. Software clears flags by writing ones. Three sticky cause bits show which error raised the shared error factor. A port level register is compared with the CPU's current mask level. A request leaves the block only when an enabled factor is pending and the port level is strictly above the mask. When several factors are pending, the receive error vector is offered first, then receive done, then transmit done.

Top module: `sif_irq_ctrl`

## Requirements
- R1: After reset, all factor flags, enable bits, cause bits and the port level are 0, `irq_o` is 0 and `vector_o` is 0.
- R2: A `tx_done_i` pulse sets factor flag bit 0 (transmit done) on the next clock edge. A `rx_load_i` pulse with no error qualifier sets factor flag bit 1 (receive done). Both happen whatever the enable bits hold.
- R3: A write to address 0 clears each factor flag whose data bit is 1, and a 0 bit leaves that flag unchanged. The same applies to the cause bits at address 2. If an event sets a bit in the same cycle that a write clears it, the bit ends up 1.
- R4: Address 1 holds the enable bits, in the same bit positions as the flags. Address 3 holds the port level in its low 2 bits.
- R5: `irq_o` is 1 exactly when some factor has both its flag and its enable at 1 and the port level, as an unsigned number, is greater than `cpu_level_i`. It follows flag, enable and level changes in the same cycle.
- R6: A receive load with a parity or framing qualifier and no overrun sets both the receive error flag (bit 2) and the receive done flag (bit 1) on the same edge.
- R7: A receive load with the overrun qualifier sets the receive error flag and does not set the receive done flag, even if parity or framing is also flagged.
- R8: While `irq_o` is 1, `vector_o` is 0x00001A for receive error, 0x00001C for receive done and 0x00001E for transmit done. It gives the first requesting factor in the order receive error, receive done, transmit done. While `irq_o` is 0, `vector_o` is 0.
- R9: On a receive load, each qualifier sets its sticky cause bit: bit 0 parity, bit 1 overrun, bit 2 framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_done_i | input | 1 | Transmit done event pulse |
| rx_load_i | input | 1 | Received frame moved to buffer, event pulse |
| rx_par_err_i | input | 1 | Parity error qualifier for rx_load_i |
| rx_frm_err_i | input | 1 | Framing error qualifier for rx_load_i |
| rx_ovr_err_i | input | 1 | Overrun qualifier for rx_load_i |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 flags (W1C), 1 enables, 2 causes (W1C), 3 level |
| wr_data_i | input | 8 | Write data |
| cpu_level_i | input | 2 | CPU current interrupt mask level |
| irq_o | output | 1 | Interrupt request |
| vector_o | output | 24 | Vector address of the winning factor |
| flag_o | output | 3 | Factor flags: bit 0 tx done, bit 1 rx done, bit 2 rx error |
| err_stat_o | output | 3 | Cause bits: bit 0 parity, bit 1 overrun, bit 2 framing |

## Verification
The vector table mixes every receive kind with and without a transmit event: clean, overrun, and parity with overrun absent. This tells apart the R6 double set from the R7 error-only set. Each row also uses a different enable, level and mask setting. Level equal to the mask, level above it, and a pending factor that is disabled separate the strict comparison from a gate that is only on or off. Directed cases walk the winner down the order by clearing one flag at a time. They also check that a zero write changes nothing and that a set beats a clear landing in the same cycle.

// File: rtl/sif_irq_pkg.sv
package sif_irq_pkg;
   localparam int NUM_FACTORS = 3;
   localparam int NUM_CAUSES  = 3;

   // factor flag positions; index order is also arbitration rank (high wins)
   localparam int F_TX  = 0;
   localparam int F_RX  = 1;
   localparam int F_ERR = 2;

   // cause bit positions
   localparam int C_PAR = 0;
   localparam int C_OVR = 1;
   localparam int C_FRM = 2;

   typedef enum logic [1:0] {
      REG_FLAGS  = 2'd0,
      REG_ENABLE = 2'd1,
      REG_CAUSE  = 2'd2,
      REG_LEVEL  = 2'd3
   } sif_reg_e;
endpackage

// File: rtl/sif_irq_w1c.sv
module sif_irq_w1c #(
   parameter int N        = 3,
   parameter bit SET_WINS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q_o
);
   if (N < 1) begin : g_bad_n
      $error("sif_irq_w1c: N must be at least 1");
   end

   logic [N-1:0] q_q;
   logic [N-1:0] q_d;

   for (genvar i = 0; i < N; i++) begin : g_bit
      if (SET_WINS) begin : g_set_first
         assign q_d[i] = set_i[i] | (q_q[i] & ~clr_i[i]);
      end else begin : g_clr_first
         assign q_d[i] = ~clr_i[i] & (set_i[i] | q_q[i]);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_q[i] <= 1'b0;
         else        q_q[i] <= q_d[i];
      end

      if (SET_WINS) begin : g_chk_set
         // R2 / R3: an event always lands, even against a clear
         a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> q_o[i]);
      end
      // R3: clearing without a concurrent set drops the bit
      a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[i] && !set_i[i]) |=> !q_o[i]);
      // R3: a zero write bit keeps a set bit
      a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (q_o[i] && !clr_i[i]) |=> q_o[i]);
      // R2: no bit appears without its event
      a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
         (!q_o[i] && !set_i[i]) |=> !q_o[i]);
   end

   assign q_o = q_q;
endmodule

// File: rtl/sif_irq_evt.sv
module sif_irq_evt
   import sif_irq_pkg::*;
(
   input  logic                   tx_done_i,
   input  logic                   rx_load_i,
   input  logic                   rx_par_err_i,
   input  logic                   rx_frm_err_i,
   input  logic                   rx_ovr_err_i,
   output logic [NUM_FACTORS-1:0] factor_set_o,
   output logic [NUM_CAUSES-1:0]  cause_set_o
);
   logic any_err;

   always_comb begin
      any_err = rx_par_err_i | rx_frm_err_i | rx_ovr_err_i;

      factor_set_o        = '0;
      factor_set_o[F_TX]  = tx_done_i;
      // an overrun loses the frame, so no receive-done factor for it
      factor_set_o[F_RX]  = rx_load_i & ~rx_ovr_err_i;
      factor_set_o[F_ERR] = rx_load_i & any_err;

      cause_set_o         = '0;
      cause_set_o[C_PAR]  = rx_load_i & rx_par_err_i;
      cause_set_o[C_OVR]  = rx_load_i & rx_ovr_err_i;
      cause_set_o[C_FRM]  = rx_load_i & rx_frm_err_i;
   end
endmodule

// File: rtl/sif_irq_arb.sv
module sif_irq_arb #(
   parameter int NF    = 3,
   parameter int LVL_W = 2,
   parameter int VEC_W = 24,
   parameter logic [NF-1:0][VEC_W-1:0] VECTORS = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NF-1:0]    flag_i,
   input  logic [NF-1:0]    en_i,
   input  logic [LVL_W-1:0] port_level_i,
   input  logic [LVL_W-1:0] cpu_level_i,
   output logic             irq_o,
   output logic [VEC_W-1:0] vector_o
);
   logic [NF-1:0] req;
   logic [NF-1:0] sel;
   logic [NF:0]   above;   // above[i]: some request ranked at i or higher
   logic          level_ok;
   logic [NF-1:0][VEC_W-1:0] vec_term;

   assign above[NF] = 1'b0;

   for (genvar i = NF - 1; i >= 0; i--) begin : g_rank
      assign req[i]      = flag_i[i] & en_i[i];
      assign sel[i]      = req[i] & ~above[i+1];
      assign above[i]    = above[i+1] | req[i];
      assign vec_term[i] = sel[i] ? VECTORS[i] : '0;
   end

   assign level_ok = port_level_i > cpu_level_i;

   always_comb begin
      vector_o = '0;
      for (int i = 0; i < NF; i++) begin
         vector_o = vector_o | vec_term[i];
      end
      if (!level_ok) vector_o = '0;
   end

   assign irq_o = level_ok & above[0];

   // R8: a single winner at any time
   a_r8_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));
   // R8: nothing requested means no vector
   a_r8_idle_vector: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_o |-> (vector_o == '0));
endmodule

// File: rtl/sif_irq_ctrl.sv
module sif_irq_ctrl
   import sif_irq_pkg::*;
#(
   parameter int   LVL_W    = 2,
   parameter int   DATA_W   = 8,
   parameter int   VEC_W    = 24,
   parameter bit   SET_WINS = 1'b1,
   parameter logic [VEC_W-1:0] TX_VEC  = 24'h00001E,
   parameter logic [VEC_W-1:0] RX_VEC  = 24'h00001C,
   parameter logic [VEC_W-1:0] ERR_VEC = 24'h00001A
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   tx_done_i,
   input  logic                   rx_load_i,
   input  logic                   rx_par_err_i,
   input  logic                   rx_frm_err_i,
   input  logic                   rx_ovr_err_i,
   input  logic                   wr_en_i,
   input  logic [1:0]             wr_addr_i,
   input  logic [DATA_W-1:0]      wr_data_i,
   input  logic [LVL_W-1:0]       cpu_level_i,
   output logic                   irq_o,
   output logic [VEC_W-1:0]       vector_o,
   output logic [NUM_FACTORS-1:0] flag_o,
   output logic [NUM_CAUSES-1:0]  err_stat_o
);
   localparam int MIN_DATA_W = (LVL_W > NUM_FACTORS) ? LVL_W : NUM_FACTORS;
   localparam logic [NUM_FACTORS-1:0][VEC_W-1:0] VEC_TABLE = {ERR_VEC, RX_VEC, TX_VEC};

   if (LVL_W < 1) begin : g_bad_lvl
      $error("sif_irq_ctrl: LVL_W must be at least 1");
   end
   if (DATA_W < MIN_DATA_W) begin : g_bad_data
      $error("sif_irq_ctrl: DATA_W too narrow for the register fields");
   end
   if (VEC_W < 5) begin : g_bad_vec
      $error("sif_irq_ctrl: VEC_W too narrow for the vectors");
   end

   logic                   wr_flags, wr_enable, wr_cause, wr_level;
   logic [NUM_FACTORS-1:0] factor_set, factor_clr, flag_q;
   logic [NUM_CAUSES-1:0]  cause_set, cause_clr, cause_q;
   logic [NUM_FACTORS-1:0] en_q;
   logic [LVL_W-1:0]       lvl_q;

   always_comb begin
      wr_flags  = wr_en_i && (wr_addr_i == REG_FLAGS);
      wr_enable = wr_en_i && (wr_addr_i == REG_ENABLE);
      wr_cause  = wr_en_i && (wr_addr_i == REG_CAUSE);
      wr_level  = wr_en_i && (wr_addr_i == REG_LEVEL);
      factor_clr = wr_flags ? wr_data_i[NUM_FACTORS-1:0] : '0;
      cause_clr  = wr_cause ? wr_data_i[NUM_CAUSES-1:0]  : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         lvl_q <= '0;
      end else begin
         if (wr_enable) en_q  <= wr_data_i[NUM_FACTORS-1:0];
         if (wr_level)  lvl_q <= wr_data_i[LVL_W-1:0];
      end
   end

   sif_irq_evt u_evt (
      .tx_done_i    (tx_done_i),
      .rx_load_i    (rx_load_i),
      .rx_par_err_i (rx_par_err_i),
      .rx_frm_err_i (rx_frm_err_i),
      .rx_ovr_err_i (rx_ovr_err_i),
      .factor_set_o (factor_set),
      .cause_set_o  (cause_set)
   );

   sif_irq_w1c #(.N(NUM_FACTORS), .SET_WINS(SET_WINS)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (factor_set),
      .clr_i (factor_clr),
      .q_o   (flag_q)
   );

   sif_irq_w1c #(.N(NUM_CAUSES), .SET_WINS(SET_WINS)) u_causes (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (cause_set),
      .clr_i (cause_clr),
      .q_o   (cause_q)
   );

   sif_irq_arb #(
      .NF      (NUM_FACTORS),
      .LVL_W   (LVL_W),
      .VEC_W   (VEC_W),
      .VECTORS (VEC_TABLE)
   ) u_arb (
      .clk          (clk),
      .rst_n        (rst_n),
      .flag_i       (flag_q),
      .en_i         (en_q),
      .port_level_i (lvl_q),
      .cpu_level_i  (cpu_level_i),
      .irq_o        (irq_o),
      .vector_o     (vector_o)
   );

   assign flag_o     = flag_q;
   assign err_stat_o = cause_q;

   // R6: parity or framing without overrun raises both receive factors
   a_r6_both_set: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_load_i && (rx_par_err_i || rx_frm_err_i) && !rx_ovr_err_i)
      |=> (flag_o[F_RX] && flag_o[F_ERR]));
   // R7: an overrun never raises the receive-done factor
   a_r7_overrun_no_rx: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_load_i && rx_ovr_err_i && !flag_o[F_RX]) |=> !flag_o[F_RX]);
   // R7: an overrun always raises the error factor and its cause
   a_r7_overrun_err: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_load_i && rx_ovr_err_i) |=> (flag_o[F_ERR] && err_stat_o[C_OVR]));
   // R5: a port level not above the mask blocks the request
   a_r5_level_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q <= cpu_level_i) |-> !irq_o);
   // R8: a pending enabled error always takes the vector
   a_r8_err_first: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && flag_o[F_ERR] && en_q[F_ERR]) |-> (vector_o == ERR_VEC));
endmodule

// File: tb/tb_sif_irq_ctrl.sv
module tb_sif_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_done_i = 1'b0, rx_load_i = 1'b0;
   logic        rx_par_err_i = 1'b0, rx_frm_err_i = 1'b0, rx_ovr_err_i = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [1:0]  wr_addr_i = 2'd0;
   logic [7:0]  wr_data_i = 8'd0;
   logic [1:0]  cpu_level_i = 2'd0;
   logic        irq_o;
   logic [23:0] vector_o;
   logic [2:0]  flag_o, err_stat_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   sif_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n),
      .tx_done_i(tx_done_i), .rx_load_i(rx_load_i),
      .rx_par_err_i(rx_par_err_i), .rx_frm_err_i(rx_frm_err_i),
      .rx_ovr_err_i(rx_ovr_err_i),
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .cpu_level_i(cpu_level_i),
      .irq_o(irq_o), .vector_o(vector_o), .flag_o(flag_o), .err_stat_o(err_stat_o)
   );

   always #5 clk = ~clk;

   // row: [23:21] enable, [20:19] level, [18:17] mask, [16] tx event,
   //      [15:14] rx kind (0 none, 1 clean, 2 overrun, 3 parity), [8] irq, [7:0] vector
   localparam int NROWS = 12;
   localparam logic [23:0] ROWS [NROWS] = '{
      {3'b001, 2'd1, 2'd0, 1'b1, 2'd0, 5'd0, 1'b1, 8'h1E},
      {3'b001, 2'd0, 2'd0, 1'b1, 2'd0, 5'd0, 1'b0, 8'h00},
      {3'b010, 2'd2, 2'd1, 1'b0, 2'd1, 5'd0, 1'b1, 8'h1C},
      {3'b011, 2'd3, 2'd2, 1'b1, 2'd1, 5'd0, 1'b1, 8'h1C},
      {3'b111, 2'd3, 2'd0, 1'b1, 2'd3, 5'd0, 1'b1, 8'h1A},
      {3'b011, 2'd3, 2'd0, 1'b0, 2'd2, 5'd0, 1'b0, 8'h00},
      {3'b100, 2'd1, 2'd0, 1'b0, 2'd2, 5'd0, 1'b1, 8'h1A},
      {3'b110, 2'd2, 2'd2, 1'b0, 2'd3, 5'd0, 1'b0, 8'h00},
      {3'b101, 2'd3, 2'd3, 1'b1, 2'd0, 5'd0, 1'b0, 8'h00},
      {3'b001, 2'd3, 2'd2, 1'b1, 2'd3, 5'd0, 1'b1, 8'h1E},
      {3'b000, 2'd3, 2'd0, 1'b1, 2'd3, 5'd0, 1'b0, 8'h00},
      {3'b110, 2'd2, 2'd0, 1'b1, 2'd1, 5'd0, 1'b1, 8'h1C}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
      @(negedge clk);
      wr_en_i = 1'b0; wr_data_i = 8'd0;
   endtask

   // rx kind: 0 none, 1 clean, 2 overrun, 3 parity
   task automatic drive_ev(input logic tx, input logic [1:0] rx);
      tx_done_i    = tx;
      rx_load_i    = (rx != 2'd0);
      rx_ovr_err_i = (rx == 2'd2);
      rx_par_err_i = (rx == 2'd3);
      rx_frm_err_i = 1'b0;
   endtask

   task automatic idle_ev();
      tx_done_i = 1'b0; rx_load_i = 1'b0;
      rx_ovr_err_i = 1'b0; rx_par_err_i = 1'b0; rx_frm_err_i = 1'b0;
   endtask

   task automatic fire(input logic tx, input logic [1:0] rx);
      @(negedge clk);
      drive_ev(tx, rx);
      @(negedge clk);
      idle_ev();
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check("R1 flags at reset", {29'd0, flag_o}, 32'd0);
      check("R1 causes at reset", {29'd0, err_stat_o}, 32'd0);
      check("R1 irq at reset", {31'd0, irq_o}, 32'd0);
      check("R1 vector at reset", {8'd0, vector_o}, 32'd0);
      rst_n = 1'b1;

      for (int r = 0; r < NROWS; r++) begin
         logic [2:0] exp_flags, exp_cause;
         logic [1:0] rxk;
         rxk = ROWS[r][15:14];
         cpu_level_i = 2'd0;
         wr(2'd0, 8'h07);
         wr(2'd2, 8'h07);
         wr(2'd1, {5'd0, ROWS[r][23:21]});
         wr(2'd3, {6'd0, ROWS[r][20:19]});
         fire(ROWS[r][16], rxk);
         cpu_level_i = ROWS[r][18:17];
         #1;
         // R2 / R6 / R7: expected flags from the event kind
         exp_flags = {rxk >= 2'd2, (rxk == 2'd1) || (rxk == 2'd3), ROWS[r][16]};
         exp_cause = {1'b0, rxk == 2'd2, rxk == 2'd3};   // R9
         check($sformatf("R2 R6 R7 flags row %0d", r), {29'd0, flag_o}, {29'd0, exp_flags});
         check($sformatf("R9 causes row %0d", r), {29'd0, err_stat_o}, {29'd0, exp_cause});
         check($sformatf("R4 R5 irq row %0d", r), {31'd0, irq_o}, {31'd0, ROWS[r][8]});
         check($sformatf("R8 vector row %0d", r), {8'd0, vector_o}, {24'd0, ROWS[r][7:0]});
      end

      // R8: walk the winner down the order
      cpu_level_i = 2'd0;
      wr(2'd0, 8'h07); wr(2'd2, 8'h07);
      wr(2'd1, 8'h07); wr(2'd3, 8'h03);
      fire(1'b1, 2'd3);
      #1;
      check("R8 error first", {8'd0, vector_o}, 32'h1A);
      wr(2'd0, 8'h04);
      #1;
      check("R8 rx after error cleared", {8'd0, vector_o}, 32'h1C);
      wr(2'd0, 8'h02);
      #1;
      check("R8 tx last", {8'd0, vector_o}, 32'h1E);
      check("R3 w1c left tx only", {29'd0, flag_o}, 32'd1);

      // R3: zero write bits keep flags
      wr(2'd0, 8'h00);
      #1;
      check("R3 zero write keeps flag", {29'd0, flag_o}, 32'd1);

      // R3: set wins over clear in the same cycle
      wr(2'd0, 8'h07);
      @(negedge clk);
      wr_en_i = 1'b1; wr_addr_i = 2'd0; wr_data_i = 8'h01; tx_done_i = 1'b1;
      @(negedge clk);
      wr_en_i = 1'b0; wr_data_i = 8'd0; tx_done_i = 1'b0;
      #1;
      check("R3 set beats clear", {29'd0, flag_o}, 32'd1);

      // R9 / R6: framing error cause, partial cause clear
      wr(2'd0, 8'h07); wr(2'd2, 8'h07);
      @(negedge clk);
      rx_load_i = 1'b1; rx_frm_err_i = 1'b1; rx_par_err_i = 1'b1;
      @(negedge clk);
      idle_ev();
      #1;
      check("R6 framing sets rx and error", {29'd0, flag_o}, 32'h6);
      check("R9 framing and parity causes", {29'd0, err_stat_o}, 32'h5);
      wr(2'd2, 8'h01);
      #1;
      check("R3 cause w1c parity only", {29'd0, err_stat_o}, 32'h4);

      // R7: overrun with parity still skips receive done
      wr(2'd0, 8'h07); wr(2'd2, 8'h07);
      @(negedge clk);
      rx_load_i = 1'b1; rx_ovr_err_i = 1'b1; rx_par_err_i = 1'b1;
      @(negedge clk);
      idle_ev();
      #1;
      check("R7 overrun with parity", {29'd0, flag_o}, 32'h4);

      // R5: enable cleared drops request while flag stays
      wr(2'd1, 8'h00);
      #1;
      check("R5 disabled no irq", {31'd0, irq_o}, 32'd0);
      check("R2 flag kept while disabled", {29'd0, flag_o}, 32'h4);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule